// File: doc/BRIEF.md
# Block Lock Protection Guard

This block keeps one lock flag for each block of a storage array and one master lock flag. It decides whether each incoming request may proceed. A request can be an erase, a program, setting one block's lock, setting the master lock, or clearing every block lock. The decision depends on three things together: the master flag, the lock flag of the addressed block, and a `hv_en` input. That input stands in for an elevated supply level, which acts as an override.

Each request is presented for one cycle with `req_valid`. One cycle later the block answers with a one-cycle `grant` or `deny` pulse. Lock changes caused by a granted request take effect at the same edge. The full lock state is visible at all times on `lock_vec` and `master_lock`. A single block can also be read back through `rd_blk` and `rd_locked`. The lock flags start from parameter values at reset, because there is no non-volatile storage.

Top module: `blk_lock_guard`

## Requirements
- R1: While `rst_n` is low, `lock_vec` equals the parameter `LOCK_INIT`, `master_lock` equals `MASTER_INIT`, and `grant` and `deny` are low.
- R2: An erase (`req_op`=0) or program (`req_op`=1) to an in-range block whose lock flag is clear is granted for either value of `hv_en`.
- R3: An erase or program to a locked block is granted only when `hv_en` is high, and is denied otherwise.
- R4: Setting one block's lock (`req_op`=2) is granted without `hv_en` while the master flag is clear. While the master flag is set it needs `hv_en`. When granted, it sets only the addressed bit of `lock_vec`.
- R5: Setting the master lock (`req_op`=3) is granted only with `hv_en` high, and when granted it makes `master_lock` high.
- R6: Clearing block locks (`req_op`=4) needs `hv_en` only while the master flag is set. When granted, it zeroes every bit of `lock_vec` at the same edge.
- R7: Each request with `req_valid` high gives exactly one of `grant` or `deny`, as a one-cycle pulse in the following cycle. A denied request leaves `lock_vec` and `master_lock` unchanged. Without a request, both outputs stay low.
- R8: No request lowers `master_lock`. Only reset returns it to `MASTER_INIT`.
- R9: Op codes 5 to 7 are denied. So is an erase, program or block-lock request whose `req_blk` is `NBLK` or above. The index is not checked for op codes 3 and 4.
- R10: `rd_locked` shows, without a clock delay, the current lock flag of block `rd_blk`, and reads 0 for an index of `NBLK` or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 erase, 1 program, 2 set block lock, 3 set master lock, 4 clear all block locks |
| req_blk | input | IW | Target block index |
| hv_en | input | 1 | Elevated-level override |
| grant | output | 1 | Request permitted (pulse, next cycle) |
| deny | output | 1 | Request refused (pulse, next cycle) |
| lock_vec | output | NBLK | Current block lock flags |
| master_lock | output | 1 | Current master lock flag |
| rd_blk | input | IW | Readback block index |
| rd_locked | output | 1 | Lock flag of block `rd_blk` |

## Verification
A wrong lock or master flag shows on `lock_vec` or `master_lock` in the cycle after the faulty edge. It also changes the next request's `grant`/`deny` answer, one cycle after that request. If the decision logic itself is wrong, the output pulse is inverted in the cycle after the request. A missed or stray update shows as a mismatched bit. The bench's model checks every output after every edge, so any mistake is reported at most one cycle after it happens.

// File: rtl/lkg_pkg.sv
package lkg_pkg;

  typedef enum logic [2:0] {
    LK_ERASE  = 3'd0,
    LK_PROG   = 3'd1,
    LK_SETBLK = 3'd2,
    LK_SETMST = 3'd3,
    LK_CLRALL = 3'd4
  } lk_op_e;

  // Permission rule for one request, given the state it depends on.
  function automatic logic permit(
    input logic [2:0] op,
    input logic       in_range,
    input logic       tgt_locked,
    input logic       master,
    input logic       hv
  );
    logic ok;
    case (op)
      LK_ERASE, LK_PROG: ok = in_range && (!tgt_locked || hv);
      LK_SETBLK:         ok = in_range && (!master || hv);
      LK_SETMST:         ok = hv;
      LK_CLRALL:         ok = !master || hv;
      default:           ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/lkg_policy.sv
module lkg_policy #(
  parameter int NBLK = 12,
  parameter int IW   = 4
) (
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [IW-1:0]   req_blk,
  input  logic            hv_en,
  input  logic [NBLK-1:0] locks,
  input  logic            master,
  output logic            ok_c,
  output logic            deny_c,
  output logic            set_blk_fire,
  output logic            set_mst_fire,
  output logic            clr_fire,
  output logic [NBLK-1:0] tgt_hot
);
  import lkg_pkg::*;

  logic in_range;
  logic tgt_locked;
  logic allowed;

  assign in_range = (int'(req_blk) < NBLK);

  always_comb begin
    tgt_locked = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      if (req_blk == IW'(i)) tgt_locked = locks[i];
    end
  end

  for (genvar g = 0; g < NBLK; g++) begin : g_hot
    assign tgt_hot[g] = (req_blk == IW'(g));
  end

  assign allowed      = permit(req_op, in_range, tgt_locked, master, hv_en);
  assign ok_c         = req_valid && allowed;
  assign deny_c       = req_valid && !allowed;
  assign set_blk_fire = ok_c && (req_op == LK_SETBLK);
  assign set_mst_fire = ok_c && (req_op == LK_SETMST);
  assign clr_fire     = ok_c && (req_op == LK_CLRALL);

endmodule

// File: rtl/lkg_lock_bank.sv
module lkg_lock_bank #(
  parameter int              NBLK        = 12,
  parameter logic [NBLK-1:0] LOCK_INIT   = '0,
  parameter logic            MASTER_INIT = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_blk_fire,
  input  logic            set_mst_fire,
  input  logic            clr_fire,
  input  logic [NBLK-1:0] tgt_hot,
  output logic [NBLK-1:0] locks,
  output logic            master
);

  logic any_upd;
  assign any_upd = set_blk_fire || set_mst_fire || clr_fire;

  for (genvar g = 0; g < NBLK; g++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          b_q <= LOCK_INIT[g];
      else if (clr_fire)                   b_q <= 1'b0;
      else if (set_blk_fire && tgt_hot[g]) b_q <= 1'b1;
    end
    assign locks[g] = b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            master <= MASTER_INIT;
    else if (set_mst_fire) master <= 1'b1;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_upd |=> ($stable(locks) && $stable(master)));

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (locks == '0));

  p_master_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    master |=> master);

  p_single_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_blk_fire |=> ($countones(locks & ~$past(locks)) <= 1));

endmodule

// File: rtl/lkg_resp.sv
module lkg_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic ok_c,
  input  logic deny_c,
  output logic grant,
  output logic deny
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= ok_c;
      deny  <= deny_c;
    end
  end

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  p_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |-> $past(req_valid));

  p_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant || deny));

endmodule

// File: rtl/blk_lock_guard.sv
module blk_lock_guard #(
  parameter int              NBLK        = 12,
  parameter logic [NBLK-1:0] LOCK_INIT   = '0,
  parameter logic            MASTER_INIT = 1'b0,
  localparam int             IW          = (NBLK > 1) ? $clog2(NBLK) + 1 : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [IW-1:0]   req_blk,
  input  logic            hv_en,
  output logic            grant,
  output logic            deny,
  output logic [NBLK-1:0] lock_vec,
  output logic            master_lock,
  input  logic [IW-1:0]   rd_blk,
  output logic            rd_locked
);
  import lkg_pkg::*;

  logic            ok_c;
  logic            deny_c;
  logic            set_blk_fire;
  logic            set_mst_fire;
  logic            clr_fire;
  logic [NBLK-1:0] tgt_hot;

  lkg_policy #(.NBLK(NBLK), .IW(IW)) u_policy (
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_blk      (req_blk),
    .hv_en        (hv_en),
    .locks        (lock_vec),
    .master       (master_lock),
    .ok_c         (ok_c),
    .deny_c       (deny_c),
    .set_blk_fire (set_blk_fire),
    .set_mst_fire (set_mst_fire),
    .clr_fire     (clr_fire),
    .tgt_hot      (tgt_hot)
  );

  lkg_lock_bank #(.NBLK(NBLK), .LOCK_INIT(LOCK_INIT), .MASTER_INIT(MASTER_INIT)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_blk_fire (set_blk_fire),
    .set_mst_fire (set_mst_fire),
    .clr_fire     (clr_fire),
    .tgt_hot      (tgt_hot),
    .locks        (lock_vec),
    .master       (master_lock)
  );

  lkg_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ok_c      (ok_c),
    .deny_c    (deny_c),
    .grant     (grant),
    .deny      (deny)
  );

  // Readback mux; indices past the array read as unlocked.
  always_comb begin
    rd_locked = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      if (rd_blk == IW'(i)) rd_locked = lock_vec[i];
    end
  end

  logic wr_locked_low;
  always_comb begin
    wr_locked_low = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      if (req_blk == IW'(i) && lock_vec[i]) wr_locked_low = 1'b1;
    end
    wr_locked_low = wr_locked_low && req_valid && !hv_en &&
                    (req_op == LK_ERASE || req_op == LK_PROG);
  end

  p_locked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_locked_low |=> (deny && !grant));

  p_master_hv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == LK_SETMST && !hv_en) |=> deny);

  p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op > 3'd4) |=> deny);

endmodule

// File: tb/sim_blk_lock_guard.sv
module sim_blk_lock_guard;
  localparam int          N    = 12;
  localparam int          IW   = 5;
  localparam logic [11:0] INIT = 12'h0A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [IW-1:0] req_blk = '0;
  logic hv_en = 1'b0;
  logic [IW-1:0] rd_blk = '0;
  logic grant, deny, master_lock, rd_locked;
  logic [N-1:0] lock_vec;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mlock[N];
  int mmaster;

  always #5 clk = ~clk;

  blk_lock_guard #(.NBLK(N), .LOCK_INIT(INIT), .MASTER_INIT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_blk(req_blk), .hv_en(hv_en), .grant(grant), .deny(deny),
    .lock_vec(lock_vec), .master_lock(master_lock), .rd_blk(rd_blk),
    .rd_locked(rd_locked)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_ok(input int op, input int blk, input int hv);
    if (op == 0 || op == 1) begin
      if (blk >= N) return 0;
      if (mlock[blk] == 0) return 1;
      return hv;
    end
    if (op == 2) begin
      if (blk >= N) return 0;
      if (mmaster == 0) return 1;
      return hv;
    end
    if (op == 3) return hv;
    if (op == 4) begin
      if (mmaster == 0) return 1;
      return hv;
    end
    return 0;
  endfunction

  function automatic int model_vec();
    int v = 0;
    for (int i = 0; i < N; i++) v = v | (mlock[i] << i);
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) mlock[i] = int'(INIT[i]);
    mmaster = 0;
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input string tag, input int v, input int op, input int blk, input int hv);
    int ok, eg, ed, rexp;
    req_valid = v[0];
    req_op    = op[2:0];
    req_blk   = blk[IW-1:0];
    hv_en     = hv[0];
    rd_blk    = blk[IW-1:0];
    ok = model_ok(op, blk, hv);
    eg = (v != 0) && (ok != 0);
    ed = (v != 0) && (ok == 0);
    if (eg != 0) begin
      if (op == 2) mlock[blk] = 1;
      if (op == 3) mmaster = 1;
      if (op == 4) for (int i = 0; i < N; i++) mlock[i] = 0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    rexp = (blk < N) ? mlock[blk] : 0;
    chk(tag, "grant", int'(grant), eg);
    chk(tag, "deny", int'(deny), ed);
    chk(tag, "lock_vec", int'(lock_vec), model_vec());
    chk(tag, "master_lock", int'(master_lock), mmaster);
    chk("R10", "rd_locked", int'(rd_locked), rexp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", "reset lock_vec", int'(lock_vec), int'(INIT));
    chk("R1", "reset master", int'(master_lock), 0);
    chk("R1", "reset grant", int'(grant), 0);
    chk("R1", "reset deny", int'(deny), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step("R2", 1, 0, 1, 0);   // erase unlocked, no override
    step("R2", 1, 1, 3, 1);   // program unlocked, override
    step("R3", 1, 1, 0, 0);   // program locked -> deny
    step("R3", 1, 0, 5, 1);   // erase locked with override
    step("R7", 0, 0, 0, 0);   // idle
    step("R4", 1, 2, 3, 0);   // set lock, master clear
    step("R6", 1, 4, 0, 0);   // clear all, master clear
    step("R4", 1, 2, 4, 0);
    step("R4", 1, 2, 6, 0);
    step("R5", 1, 3, 0, 0);   // master set without override -> deny
    step("R5", 1, 3, 0, 1);   // master set
    step("R4", 1, 2, 8, 0);   // denied under master
    step("R4", 1, 2, 8, 1);
    step("R6", 1, 4, 0, 0);   // denied, state kept
    step("R7", 1, 1, 4, 0);   // denied program
    step("R6", 1, 4, 0, 1);   // clear all with override
    step("R8", 0, 0, 0, 0);
    step("R9", 1, 5, 2, 1);
    step("R9", 1, 7, 2, 1);
    step("R9", 1, 0, 13, 1);
    step("R9", 1, 2, 15, 0);
    step("R9", 1, 4, 31, 1);  // index ignored for clear-all

    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R8", "master after reset", int'(master_lock), 0);
    chk("R1", "locks after reset", int'(lock_vec), int'(INIT));
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 400; k++) begin
      int op = int'($urandom_range(0, 7));
      if (op > 4 && ($urandom_range(0, 3) != 0)) op = int'($urandom_range(0, 2));
      step("R7", int'($urandom_range(0, 5) != 0), op,
           int'($urandom_range(0, 13)), int'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule